// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Reload and Capture

This block is a 16-bit timer/counter for a peripheral bus. Software reaches three 16-bit registers through a simple write port and a combinational read port: a control word, the live count value and a reload/compare value. The counter advances on ticks of a prescaled system clock or on falling edges of an external count pin. Both external pins pass through a synchronizer before any edge is detected.

Three counting modes are supported. Plain auto-reload counts up and returns to zero after matching the reload value or after passing FFFFh. Capture counts up freely and copies the live count into the reload register on a falling edge of the trigger pin. Up/down auto-reload takes its direction from the trigger pin level and reloads on underflow. In up/down mode the trigger flag toggles on every wrap and acts as a seventeenth count bit.

Two sticky flags feed a single interrupt request. A clock-output mode bit masks the overflow term of that interrupt.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the control, count and reload registers all read 0000h and `irq` is 0.
- R2: With bit 15 = 0, the count advances only while the run bit (bit 2) is 1. It advances once every N system clocks, where bits 10:8 select N: 0→1, 1→4, 2→16, 3→64, 4→256, 5→1024, 6 and 7→1. While bit 2 is 0 the count holds.
- R3: With bit 15 = 1 and bit 2 = 1, the count advances once for each falling edge of `cnt_pin` and at no other time.
- R4: Outside capture mode and up/down mode, an up step from a count equal to the reload register, or from FFFFh, gives 0000h. In capture mode (bit 0 = 1) only the step from FFFFh wraps. Every wrap sets the overflow flag (bit 7).
- R5: In capture mode, with bit 3 = 1 and bit 15 = 0, a falling edge of `trig_pin` copies the current count into the reload register and sets bit 6. The reload register changes only through a write or a capture.
- R6: With bit 3 = 1 and bit 15 = 0, a falling edge of `trig_pin` sets bit 6 in capture mode or when bit 4 = 0, even while bit 2 is 0. The edge sets nothing when bit 3 = 0 or bit 15 = 1.
- R7: Up/down mode is selected by bit 0 = 0, bit 4 = 1 and bits 12:11 = 00. In this mode a `trig_pin` level of 1 counts up as in R4. A level of 0 counts down, and a down step from 0000h loads the reload value and sets bit 7.
- R8: In up/down mode, bit 6 inverts on every wrap or underflow.
- R9: `irq` = (bit 7 AND bit 1 AND NOT bit 5) OR (bit 6 AND bit 1 AND NOT up/down mode).
- R10: Bits 7 and 6 stay set until a control write. Bit 6 is also cleared by its toggling in up/down mode. A control write loads every control bit from the written value and takes priority over any hardware update in the same cycle.
- R11: Bits 14:13 of the control word always read 0. Select value 0 addresses the control word, 1 the count, 2 the reload register, and 3 reads 0000h.
- R12: The count and reload registers read back the value last written, as long as no counting or capture has occurred since the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 control, 1 count, 2 reload) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Read data, combinational from `rd_sel` |
| cnt_pin | input | 1 | External count pin, falling edges counted |
| trig_pin | input | 1 | External trigger / direction pin |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge where it is sampled and can be read back half a cycle later. An internal tick moves the count at that same edge. The prescaler gives its first tick N edges after the run bit is written. A pin change reaches the two-flop synchronizer at the next edge. Its falling edge acts at the third rising edge after the change.

The bench drives inputs and samples outputs on falling clock edges. For each check it counts the intervening rising edges and computes the expected count, flags and captured value from that number.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned PS_W   = 10;

    typedef struct packed {
        logic       src_ext;
        logic [1:0] rsvd;
        logic [1:0] out_mode;
        logic [2:0] div_sel;
        logic       wrap_flag;
        logic       trig_flag;
        logic       clk_out;
        logic       updn;
        logic       trig_en;
        logic       run;
        logic       irq_en;
        logic       cap;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    function automatic logic [PS_W-1:0] ps_limit(input logic [2:0] sel);
        case (sel)
            3'd1:    return PS_W'(3);
            3'd2:    return PS_W'(15);
            3'd3:    return PS_W'(63);
            3'd4:    return PS_W'(255);
            3'd5:    return PS_W'(1023);
            default: return '0;
        endcase
    endfunction

    function automatic logic toggle_mode(input ctrl_t c);
        return !c.cap && c.updn && (c.out_mode == 2'b00);
    endfunction

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic prev_level
);

    typedef struct packed {
        logic [DEPTH-1:0] chain;
        logic             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[DEPTH-2:0], pin};
        st_d.prev  = st_q.chain[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level      = st_q.chain[DEPTH-1];
    assign prev_level = st_q.prev;

endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc
    import tmr16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] div_sel,
    output logic       tick
);

    logic [PS_W-1:0] cnt_d, cnt_q;
    logic [PS_W-1:0] limit;

    always_comb begin
        limit = ps_limit(div_sel);
        tick  = run && (cnt_q >= limit);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + PS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tmr16_step.sv
module tmr16_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] bound,
    input  logic         step,
    input  logic         use_bound,
    input  logic         down,
    output logic [W-1:0] nxt,
    output logic         wrap
);

    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (step) begin
            if (down) begin
                if (cur == '0) begin
                    nxt  = bound;
                    wrap = 1'b1;
                end else begin
                    nxt = cur - W'(1);
                end
            end else if ((use_bound && (cur == bound)) || (cur == {W{1'b1}})) begin
                nxt  = '0;
                wrap = 1'b1;
            end else begin
                nxt = cur + W'(1);
            end
        end
    end

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
    import tmr16_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              irq
);

    localparam int unsigned NPIN     = 2;
    localparam int unsigned PIN_CNT  = 0;
    localparam int unsigned PIN_TRIG = 1;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] reload;
    } state_t;

    state_t st_d, st_q;

    logic [NPIN-1:0] pin_raw, pin_lvl, pin_prev, pin_fall;

    assign pin_raw  = {trig_pin, cnt_pin};
    assign pin_fall = pin_prev & ~pin_lvl;

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        tmr16_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (pin_raw[gi]),
            .level      (pin_lvl[gi]),
            .prev_level (pin_prev[gi])
        );
    end

    logic              ps_tick;
    logic              tgl;
    logic              step;
    logic              down;
    logic              wrap;
    logic              trig_hit;
    logic [DATA_W-1:0] cnt_nx;

    tmr16_presc u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctrl.run),
        .div_sel (st_q.ctrl.div_sel),
        .tick    (ps_tick)
    );

    assign tgl  = toggle_mode(st_q.ctrl);
    assign step = st_q.ctrl.run &&
                  (st_q.ctrl.src_ext ? pin_fall[PIN_CNT] : ps_tick);
    assign down = tgl && !pin_lvl[PIN_TRIG];

    tmr16_step #(.W(DATA_W)) u_step (
        .cur       (st_q.count),
        .bound     (st_q.reload),
        .step      (step),
        .use_bound (!st_q.ctrl.cap),
        .down      (down),
        .nxt       (cnt_nx),
        .wrap      (wrap)
    );

    assign trig_hit = st_q.ctrl.trig_en && !st_q.ctrl.src_ext && pin_fall[PIN_TRIG] &&
                      (st_q.ctrl.cap || !st_q.ctrl.updn);

    always_comb begin
        st_d       = st_q;
        st_d.count = cnt_nx;
        if (wrap) begin
            st_d.ctrl.wrap_flag = 1'b1;
            if (tgl) st_d.ctrl.trig_flag = ~st_q.ctrl.trig_flag;
        end
        if (trig_hit) begin
            st_d.ctrl.trig_flag = 1'b1;
            if (st_q.ctrl.cap) st_d.reload = st_q.count;
        end
        if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_CTRL: begin
                    st_d.ctrl      = ctrl_t'(wr_data);
                    st_d.ctrl.rsvd = '0;
                end
                SEL_COUNT:  st_d.count  = wr_data;
                SEL_RELOAD: st_d.reload = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [DATA_W-1:0] ctrl_word, cnt_word, rld_word;

    assign ctrl_word = st_q.ctrl;
    assign cnt_word  = st_q.count;
    assign rld_word  = st_q.reload;

    always_comb begin
        case (sel_e'(rd_sel))
            SEL_CTRL:   rd_data = ctrl_word;
            SEL_COUNT:  rd_data = cnt_word;
            SEL_RELOAD: rd_data = rld_word;
            default:    rd_data = '0;
        endcase
    end

    assign irq = (st_q.ctrl.wrap_flag && st_q.ctrl.irq_en && !st_q.ctrl.clk_out) ||
                 (st_q.ctrl.trig_flag && st_q.ctrl.irq_en && !tgl);

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        irq,
    input logic [15:0] ctrl_word,
    input logic [15:0] cnt_word,
    input logic [15:0] rld_word
);

    logic updn_mode;
    assign updn_mode = !ctrl_word[0] && ctrl_word[4] && (ctrl_word[12:11] == 2'b00);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[14:13] == 2'b00);                                          // R11

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[2] && !wr_en) |=> $stable(cnt_word));                    // R2

    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[7] && !wr_en) |=> ctrl_word[7]);                          // R10

    AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[6] && !wr_en && !updn_mode) |=> ctrl_word[6]);            // R10

    AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ctrl_word[0]) |=> $stable(rld_word));                    // R5

    AST_CLKOUT_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[5] && (!ctrl_word[6] || updn_mode)) |-> !irq);            // R9

endmodule

bind tmr16_unit tmr16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .irq       (irq),
    .ctrl_word (ctrl_word),
    .cnt_word  (cnt_word),
    .rld_word  (rld_word)
);

// File: tb/test_tmr16_unit.sv
`timescale 1ns/1ps
module test_tmr16_unit;

    localparam logic [15:0] C_SRC  = 16'h8000;
    localparam logic [15:0] C_CAP  = 16'h0001;
    localparam logic [15:0] C_IE   = 16'h0002;
    localparam logic [15:0] C_RUN  = 16'h0004;
    localparam logic [15:0] C_TEN  = 16'h0008;
    localparam logic [15:0] C_UPDN = 16'h0010;
    localparam logic [15:0] C_CLKO = 16'h0020;
    localparam logic [15:0] C_TRG  = 16'h0040;
    localparam logic [15:0] C_OVF  = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        cnt_pin = 1'b0;
    logic        trig_pin = 1'b1;
    logic        irq;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tmr16_unit i_tmr16_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq)
    );

    function automatic int div_of(input int s);
        case (s)
            1: return 4;
            2: return 16;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] reload_count(input int n, input int r);
        return 16'(n % (r + 1));
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        rd_sel = s;
        #0.5;
        v = rd_data;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2024));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);

        // R1 reset state
        rd(2'd0, v); check("R1", "ctrl", v, 16'h0000);
        rd(2'd1, v); check("R1", "count", v, 16'h0000);
        rd(2'd2, v); check("R1", "reload", v, 16'h0000);
        check("R1", "irq", {15'h0, irq}, 16'h0000);

        // R11 reserved bits and unused select
        wr(2'd0, 16'h6000);
        rd(2'd0, v); check("R11", "reserved bits", v, 16'h0000);
        wr(2'd2, 16'h5A5A);
        rd(2'd3, v); check("R11", "select 3", v, 16'h0000);

        // R12 read back; R2 hold while stopped
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'hABCD);
        rd(2'd1, v); check("R12", "count rw", v, 16'h1234);
        rd(2'd2, v); check("R12", "reload rw", v, 16'hABCD);
        wait_n(20);
        rd(2'd1, v); check("R2", "stopped hold", v, 16'h1234);

        // R2 every prescaler setting
        for (int s = 0; s < 8; s++) begin
            int k;
            k = 2 * div_of(s) + 3;
            wr(2'd0, 16'h0);
            wr(2'd1, 16'h0);
            wr(2'd2, 16'hFFFF);
            wr(2'd0, C_RUN | 16'(s << 8));
            wait_n(k);
            rd(2'd1, v); check("R2", $sformatf("prescale sel %0d", s), v, 16'(k / div_of(s)));
        end

        // R4 random reload trials
        for (int t = 0; t < 40; t++) begin
            int s, r, k, n;
            s = int'($urandom_range(3, 0));
            r = int'($urandom_range(30, 1));
            k = int'($urandom_range(400, 1));
            n = k / div_of(s);
            wr(2'd0, 16'h0);
            wr(2'd1, 16'h0);
            wr(2'd2, 16'(r));
            wr(2'd0, C_RUN | 16'(s << 8));
            wait_n(k);
            rd(2'd1, v); check("R4", "reload count", v, reload_count(n, r));
            rd(2'd0, v); check("R4", "overflow flag", v & C_OVF, (n > r) ? C_OVF : 16'h0);
        end

        // R4 wrap from FFFFh in capture mode (compare ignored)
        wr(2'd0, 16'h0);
        wr(2'd2, 16'h0);
        wr(2'd1, 16'hFFFE);
        wr(2'd0, C_CAP | C_RUN);
        wait_n(1);
        rd(2'd1, v); check("R4", "at FFFF", v, 16'hFFFF);
        rd(2'd0, v); check("R4", "no flag yet", v & C_OVF, 16'h0);
        wait_n(1);
        rd(2'd1, v); check("R4", "wrapped", v, 16'h0000);
        rd(2'd0, v); check("R4", "flag on wrap", v & C_OVF, C_OVF);
        wait_n(5);
        rd(2'd0, v); check("R10", "flag sticky", v & C_OVF, C_OVF);

        // R10 software clear
        wr(2'd0, C_CAP);
        rd(2'd0, v); check("R10", "flag cleared", v & C_OVF, 16'h0);
        wait_n(8);
        rd(2'd0, v); check("R10", "stays clear", v & C_OVF, 16'h0);

        // R3 external count source; R6 trigger ignored with external source
        wr(2'd0, 16'h0);
        wr(2'd1, 16'h0);
        wr(2'd2, 16'hFFFF);
        wr(2'd0, C_SRC | C_RUN | C_TEN);
        for (int p = 0; p < 7; p++) begin
            cnt_pin = 1'b1; wait_n(3);
            cnt_pin = 1'b0; wait_n(3);
        end
        trig_pin = 1'b0; wait_n(4);
        trig_pin = 1'b1; wait_n(4);
        rd(2'd1, v); check("R3", "pin edge count", v, 16'd7);
        rd(2'd0, v); check("R6", "no flag with ext source", v & C_TRG, 16'h0);

        // R6 trigger flag while stopped; R9 trigger interrupt
        wr(2'd0, 16'h0);
        wr(2'd1, 16'h0);
        wr(2'd0, C_TEN | C_IE);
        trig_pin = 1'b0; wait_n(4);
        rd(2'd0, v); check("R6", "flag while stopped", v & C_TRG, C_TRG);
        check("R9", "trigger irq", {15'h0, irq}, 16'h0001);
        rd(2'd1, v); check("R6", "count unmoved", v, 16'h0);
        trig_pin = 1'b1; wait_n(4);

        // R6 no flag without trigger enable
        wr(2'd0, C_IE);
        trig_pin = 1'b0; wait_n(4);
        rd(2'd0, v); check("R6", "no flag when disabled", v & C_TRG, 16'h0);
        check("R9", "no irq", {15'h0, irq}, 16'h0);
        trig_pin = 1'b1; wait_n(4);

        // R5 capture
        wr(2'd0, 16'h0);
        wr(2'd1, 16'h0);
        wr(2'd2, 16'h0);
        wr(2'd0, C_CAP | C_TEN | C_RUN);
        wait_n(10);
        trig_pin = 1'b0;
        wait_n(5);
        rd(2'd2, v); check("R5", "captured value", v, 16'd12);
        rd(2'd0, v); check("R5", "capture flag", v & C_TRG, C_TRG);
        trig_pin = 1'b1; wait_n(4);

        // R7 R8 up/down, counting up
        wr(2'd0, 16'h0);
        wr(2'd1, 16'h0);
        wr(2'd2, 16'd5);
        wr(2'd0, C_UPDN | C_RUN);
        wait_n(20);
        rd(2'd1, v); check("R7", "up count", v, 16'd2);
        rd(2'd0, v); check("R8", "toggle after 3 wraps", v & (C_TRG | C_OVF), C_TRG | C_OVF);

        // R7 R8 up/down, counting down; R9 masking
        wr(2'd0, 16'h0);
        trig_pin = 1'b0; wait_n(4);
        wr(2'd1, 16'h0);
        wr(2'd0, C_UPDN | C_RUN | C_IE | C_CLKO);
        wait_n(15);
        rd(2'd1, v); check("R7", "down count", v, 16'd3);
        rd(2'd0, v); check("R8", "toggle after 3 underflows", v & (C_TRG | C_OVF), C_TRG | C_OVF);
        check("R9", "masked irq", {15'h0, irq}, 16'h0);
        wr(2'd0, 16'h0);
        trig_pin = 1'b1; wait_n(4);

        // R9 overflow interrupt and clock-output masking
        wr(2'd1, 16'h0);
        wr(2'd2, 16'd2);
        wr(2'd0, C_RUN | C_IE);
        wait_n(5);
        check("R9", "overflow irq", {15'h0, irq}, 16'h0001);
        wr(2'd0, C_RUN | C_IE | C_CLKO | C_OVF);
        check("R9", "clock-output mask", {15'h0, irq}, 16'h0);
        rd(2'd0, v); check("R10", "flag written set", v & C_OVF, C_OVF);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule